// File: doc/BRIEF.md
# Serial EEPROM Random-Read Sequencer

This block turns a single "read one byte" request into the series of bus operations that a two-byte-addressed serial EEPROM needs for a random read. It sits above a byte-level two-wire bus master engine. It issues one engine command at a time and waits for the engine's completion pulse before it moves to the next command. The sequence first sets the device's internal address pointer with a write that carries no data. It then uses a repeated start to switch the bus direction, reads one byte, refuses further data with a NACK and releases the bus with a stop.

A request carries a 3-bit chip select and a 12-bit word address. When the sequence ends, the block raises a one-cycle `done` pulse. At that point `rd_data` holds the byte that was read, and `err` shows whether any transmitted byte went unacknowledged. The block performs no writes, no multi-byte reads and no busy polling.

Top module: `eeprom_rdseq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `cmd_valid` are low.
- R2: A `req_valid` pulse in a cycle where `busy` is low raises `busy` in the next cycle. The first command is START, with `cmd_op` code 0. Each command is a `cmd_valid` pulse one cycle long, and the next command is issued only after `eng_done` has been seen.
- R3: The second command is a WRITE (code 2) of the device byte `{1010, cs[2:0], 0}`, which has the R/W bit clear.
- R4: Two more WRITE commands follow: first `{0000, addr[11:8]}`, then `addr[7:0]`.
- R5: Next comes a repeated start (code 1) rather than a stop, followed by a WRITE of the device byte `{1010, cs[2:0], 1}`.
- R6: The read phase issues READ (code 3), then ACK (code 4) with `cmd_ackbit` = 1 (NACK), then STOP (code 5).
- R7: `rd_data` takes `eng_rdata` as it stands at READ completion. After STOP completes, `done` is high for exactly one cycle, with `busy` low and `err` = 0.
- R8: If `eng_ackstat` = 1 at the completion of any WRITE, the next command is STOP. The following `done` then shows `err` = 1 and `rd_data` = 0.
- R9: A `req_valid` pulse while `busy` is high is ignored. This includes the cycle in which the final STOP completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request pulse |
| req_cs | input | 3 | Chip-select bits of the request |
| req_addr | input | 12 | Word address of the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | A transmitted byte was not acknowledged |
| rd_data | output | 8 | Byte read (0 on error) |
| cmd_valid | output | 1 | Command pulse to the engine |
| cmd_op | output | 3 | Command code: 0 start, 1 repeated start, 2 write, 3 read, 4 ack, 5 stop |
| cmd_wdata | output | 8 | Byte to transmit with a WRITE |
| cmd_ackbit | output | 1 | Acknowledge bit for ACK (1 = NACK) |
| eng_done | input | 1 | Engine completion pulse |
| eng_ackstat | input | 1 | ACK status of the last transmitted byte (1 = NACK) |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
A new request and the engine's final completion can land in the same cycle. The STOP completion is still being taken while `busy` is high, so the request has to be discarded rather than start a second sequence. The bench provokes this by having its engine model raise `req_valid`, with a different chip select and address, in exactly the cycle it pulses `eng_done` for the STOP. It then judges the outcome at the ports: `done` appears once, `busy` stays low afterwards, and the engine log records no further commands.

// File: rtl/rdseq_pkg.sv
// Package rdseq_pkg: command codes sent to the byte engine and the
// sequence steps of the random-read controller.
package rdseq_pkg;
    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_ACK    = 3'd4,
        OP_STOP   = 3'd5
    } op_t;

    typedef enum logic [3:0] {
        STP_START, STP_DEVW, STP_AHI, STP_ALO, STP_RSTART,
        STP_DEVR, STP_RECV, STP_NACK, STP_STOP
    } step_t;

    typedef enum logic [1:0] {
        PH_IDLE, PH_ISSUE, PH_WAIT
    } phase_t;
endpackage

// File: rtl/rdseq_req_latch.sv
// rdseq_req_latch: holds the accepted request and forms the byte that
// belongs to the current step.
// Assumes CS_W + 5 == DATA_W (4-bit control code, chip select, R/W bit)
// and ADDR_W > DATA_W.
module rdseq_req_latch
    import rdseq_pkg::*;
#(
    parameter int CS_W   = 3,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CS_W-1:0]   cs_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  step_t             step,
    output logic [DATA_W-1:0] wdata
);
    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [3:0] CTRL_CODE = 4'b1010;

    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the request when the controller accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '0;
            addr_q <= '0;
        end else if (load) begin
            cs_q   <= cs_in;
            addr_q <= addr_in;
        end
    end

    // Choose the transmit byte for the step in progress.
    always_comb begin
        unique case (step)
            STP_DEVW: wdata = {CTRL_CODE, cs_q, 1'b0};
            STP_DEVR: wdata = {CTRL_CODE, cs_q, 1'b1};
            STP_AHI:  wdata = {{(DATA_W-HI_W){1'b0}}, addr_q[ADDR_W-1:DATA_W]};
            STP_ALO:  wdata = addr_q[DATA_W-1:0];
            default:  wdata = '0;
        endcase
    end
endmodule

// File: rtl/rdseq_ctrl.sv
// rdseq_ctrl: steps through the random-read order. Each step issues a
// one-cycle command and then waits for the engine's completion pulse.
// A NACK after any transmitted byte sends the sequence straight to STOP.
// Assumes the engine pulses eng_done exactly once per command.
module rdseq_ctrl
    import rdseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  eng_done,
    input  logic  eng_ackstat,
    output logic  busy,
    output logic  cmd_valid,
    output op_t   cmd_op,
    output logic  cmd_ackbit,
    output step_t step,
    output logic  capture,
    output logic  fail,
    output logic  finish
);
    phase_t phase_q;
    step_t  step_q, step_nx;
    logic   is_tx, completing;

    assign step       = step_q;
    assign busy       = (phase_q != PH_IDLE);
    assign cmd_valid  = (phase_q == PH_ISSUE);
    assign completing = (phase_q == PH_WAIT) && eng_done;
    assign is_tx      = (step_q == STP_DEVW) || (step_q == STP_AHI) ||
                        (step_q == STP_ALO)  || (step_q == STP_DEVR);
    assign fail       = completing && is_tx && eng_ackstat;
    assign capture    = completing && (step_q == STP_RECV);
    assign finish     = completing && (step_q == STP_STOP);
    assign cmd_ackbit = (step_q == STP_NACK);

    // Map each step to its engine command code.
    always_comb begin
        unique case (step_q)
            STP_START:  cmd_op = OP_START;
            STP_RSTART: cmd_op = OP_RSTART;
            STP_RECV:   cmd_op = OP_READ;
            STP_NACK:   cmd_op = OP_ACK;
            STP_STOP:   cmd_op = OP_STOP;
            default:    cmd_op = OP_WRITE;
        endcase
    end

    // Choose the following step, or skip to STOP on a missing ACK.
    always_comb begin
        unique case (step_q)
            STP_START:  step_nx = STP_DEVW;
            STP_DEVW:   step_nx = STP_AHI;
            STP_AHI:    step_nx = STP_ALO;
            STP_ALO:    step_nx = STP_RSTART;
            STP_RSTART: step_nx = STP_DEVR;
            STP_DEVR:   step_nx = STP_RECV;
            STP_RECV:   step_nx = STP_NACK;
            default:    step_nx = STP_STOP;
        endcase
        if (fail) step_nx = STP_STOP;
    end

    // Advance phase and step on acceptance, issue and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= STP_START;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_ISSUE;
                    step_q  <= STP_START;
                end
                PH_ISSUE: phase_q <= PH_WAIT;
                default: if (eng_done) begin
                    if (step_q == STP_STOP) phase_q <= PH_IDLE;
                    else begin
                        phase_q <= PH_ISSUE;
                        step_q  <= step_nx;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rdseq_result.sv
// rdseq_result: keeps the received byte and the error flag, and forms
// the one-cycle done pulse. Both outputs clear when a new request is
// accepted and keep their values after done.
module rdseq_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              fail,
    input  logic              finish,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              done
);
    // Update data, error and done from the controller's events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            err     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                rd_data <= '0;
                err     <= 1'b0;
            end
            if (capture) rd_data <= eng_rdata;
            if (fail)    err     <= 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_rdseq.sv
// eeprom_rdseq: random read of one byte from a serial EEPROM with a
// two-byte word address, built on a byte-level bus master engine.
// Assumes one eng_done pulse per command and eng_ackstat valid with it.
module eeprom_rdseq
    import rdseq_pkg::*;
#(
    parameter int CS_W   = 3,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ackbit,
    input  logic              eng_done,
    input  logic              eng_ackstat,
    input  logic [DATA_W-1:0] eng_rdata
);
    logic  load, capture, fail, finish;
    step_t step;
    op_t   op;

    assign load   = req_valid && !busy;
    assign cmd_op = op;

    rdseq_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(load), .eng_done(eng_done),
        .eng_ackstat(eng_ackstat), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_op(op), .cmd_ackbit(cmd_ackbit), .step(step),
        .capture(capture), .fail(fail), .finish(finish)
    );

    rdseq_req_latch #(.CS_W(CS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .load(load), .cs_in(req_cs),
        .addr_in(req_addr), .step(step), .wdata(cmd_wdata)
    );

    rdseq_result #(.DATA_W(DATA_W)) i_result (
        .clk(clk), .rst_n(rst_n), .load(load), .capture(capture),
        .fail(fail), .finish(finish), .eng_rdata(eng_rdata),
        .rd_data(rd_data), .err(err), .done(done)
    );
endmodule

// File: rtl/rdseq_chk.sv
// rdseq_chk: port-level properties of eeprom_rdseq, attached by bind.
module rdseq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cmd_ackbit
);
    AST_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);                                   // R2
    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_valid && cmd_op == 3'd0));        // R2
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);                             // R2
    AST_ACK_IS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |-> cmd_ackbit);         // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                       // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                       // R7
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rd_data == '0));                    // R8
endmodule

bind eeprom_rdseq rdseq_chk #(.DATA_W(DATA_W)) i_rdseq_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ackbit(cmd_ackbit)
);

// File: tb/test_eeprom_rdseq.sv
module test_eeprom_rdseq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_cs;
    logic [11:0] req_addr;
    logic        busy, done, err, cmd_valid, cmd_ackbit;
    logic [7:0]  rd_data, cmd_wdata;
    logic [2:0]  cmd_op;
    logic        eng_done, eng_ackstat;
    logic [7:0]  eng_rdata;

    int checks = 0;
    int failures = 0;

    // engine model controls
    int         lat = 1;
    int         nack_idx = -1;
    logic [7:0] mem_byte = 8'h00;
    bit         inject_at_stop = 0;
    int         n_log = 0;
    logic [2:0] op_log [0:15];
    logic [7:0] dat_log [0:15];
    logic       ack_log [0:15];

    always #2 clk = ~clk;

    eeprom_rdseq i_eeprom_rdseq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
        .req_addr(req_addr), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_ackbit(cmd_ackbit), .eng_done(eng_done),
        .eng_ackstat(eng_ackstat), .eng_rdata(eng_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte engine model: logs each command, answers after lat cycles.
    initial begin
        int wnum;
        eng_done = 0; eng_ackstat = 0; eng_rdata = 0; wnum = 0;
        forever begin
            @(negedge clk);
            eng_done = 0;
            if (inject_at_stop && req_valid) req_valid = 0;
            if (cmd_valid) begin
                logic [2:0] op;
                logic nk;
                op = cmd_op;
                if (n_log < 16) begin
                    op_log[n_log] = cmd_op;
                    dat_log[n_log] = cmd_wdata;
                    ack_log[n_log] = cmd_ackbit;
                end
                n_log++;
                if (op == 3'd0) wnum = 0;
                nk = (op == 3'd2) && (wnum == nack_idx);
                if (op == 3'd2) wnum++;
                repeat (lat) @(negedge clk);
                eng_done = 1;
                eng_ackstat = nk;
                eng_rdata = mem_byte;
                if (op == 3'd5 && inject_at_stop) begin
                    req_valid = 1; req_cs = 3'd7; req_addr = 12'h123;
                end
            end
        end
    end

    // Issue a request and wait for done; checks the done cycle.
    task automatic run_req(input logic [2:0] cs, input logic [11:0] addr,
                           input string req, output bit got_done);
        int t;
        n_log = 0;
        @(negedge clk);
        req_valid = 1; req_cs = cs; req_addr = addr;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R2", "busy after request", busy, 1);
        got_done = 0;
        for (t = 0; t < 500 && !done; t++) @(negedge clk);
        got_done = done;
        check(done == 1'b1, req, "done seen", done, 1);
        check(busy == 1'b0, "R7", "busy low with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
    endtask

    // Compare the engine log with the order the requirements give.
    task automatic check_seq(input logic [2:0] cs, input logic [11:0] addr,
                             input int nk, input string req);
        logic [2:0] eo [0:15];
        logic [7:0] ed [0:15];
        logic [7:0] wb [0:3];
        int n = 0;
        wb[0] = {4'b1010, cs, 1'b0};
        wb[1] = {4'b0000, addr[11:8]};
        wb[2] = addr[7:0];
        wb[3] = {4'b1010, cs, 1'b1};
        eo[n] = 3'd0; ed[n] = 0; n++;
        for (int k = 0; k < 4; k++) begin
            if (k == 3) begin eo[n] = 3'd1; ed[n] = 0; n++; end
            eo[n] = 3'd2; ed[n] = wb[k]; n++;
            if (k == nk) break;
        end
        if (nk < 0) begin
            eo[n] = 3'd3; ed[n] = 0; n++;
            eo[n] = 3'd4; ed[n] = 0; n++;
        end
        eo[n] = 3'd5; ed[n] = 0; n++;
        check(n_log == n, req, "command count", n_log, n);
        for (int i = 0; i < n && i < n_log; i++) begin
            check(op_log[i] == eo[i], req, $sformatf("op #%0d", i), op_log[i], eo[i]);
            if (eo[i] == 3'd2)
                check(dat_log[i] == ed[i], req, $sformatf("byte #%0d", i), dat_log[i], ed[i]);
            if (eo[i] == 3'd4)
                check(ack_log[i] == 1'b1, "R6", "nack bit", ack_log[i], 1);
        end
    endtask

    task automatic t_reset();
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(done == 0, "R1", "done in reset", done, 0);
        check(cmd_valid == 0, "R1", "cmd_valid in reset", cmd_valid, 0);
    endtask

    task automatic t_good(input logic [2:0] cs, input logic [11:0] addr,
                          input logic [7:0] d, input int l);
        bit g;
        lat = l; nack_idx = -1; mem_byte = d;
        run_req(cs, addr, "R7", g);
        check(err == 0, "R7", "err clear", err, 0);
        check(rd_data == d, "R7", "read byte", rd_data, d);
        check_seq(cs, addr, -1, "R3 R4 R5 R6");
    endtask

    task automatic t_nack(input int k);
        bit g;
        lat = 2; nack_idx = k; mem_byte = 8'hEE;
        run_req(3'd2, 12'h9A7, "R8", g);
        check(err == 1, "R8", "err set", err, 1);
        check(rd_data == 0, "R8", "no data", rd_data, 0);
        check_seq(3'd2, 12'h9A7, k, "R8");
        nack_idx = -1;
    endtask

    task automatic t_busy_ignore();
        bit g;
        int t;
        lat = 2; nack_idx = -1; mem_byte = 8'h3C;
        n_log = 0;
        @(negedge clk);
        req_valid = 1; req_cs = 3'd1; req_addr = 12'h456;
        @(negedge clk);
        req_valid = 0;
        repeat (6) @(negedge clk);
        req_valid = 1; req_cs = 3'd6; req_addr = 12'hFFF;
        @(negedge clk);
        req_valid = 0;
        for (t = 0; t < 500 && !done; t++) @(negedge clk);
        check(done == 1, "R9", "done after mid request", done, 1);
        check(rd_data == 8'h3C, "R9", "data of first request", rd_data, 8'h3C);
        check_seq(3'd1, 12'h456, -1, "R9");
        // request in the STOP completion cycle
        inject_at_stop = 1; mem_byte = 8'h81;
        run_req(3'd4, 12'h0FF, "R9", g);
        inject_at_stop = 0;
        req_valid = 0;
        repeat (4) @(negedge clk);
        check(busy == 0, "R9", "no restart after stop", busy, 0);
        check(n_log == 9, "R9", "no extra commands", n_log, 9);
        check(rd_data == 8'h81, "R7", "read byte", rd_data, 8'h81);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_cs = 0; req_addr = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_good(3'd5, 12'hABC, 8'h5A, 1);
        t_good(3'd0, 12'h0FF, 8'hC3, 3);
        t_good(3'd7, 12'hF00, 8'hFF, 2);
        t_nack(0);
        t_nack(2);
        t_nack(3);
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule